// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block supervises one processor core. Once a nonzero reload length and a nonzero mode are written, it counts down one period. If the period ends without a refresh ("poke"), it does not reset the chip at once. Instead it moves up one stage. The first expiry raises an interrupt, the next raises a non-maskable interrupt, and the one after that issues a soft-reset request. Any poke drops the block back to plain counting and starts a full new period. Software can read the current stage at any time.

The 16-bit reload length fills the upper bits of a wider down-counter, and a power-of-two prescaler sits in front of it. A short field can therefore cover long intervals. With the default parameters, one period is `len × 65536` clock cycles. The mode selects how far the escalation may go. A system with several cores places one instance per core.

Top module: `wdog_escalator`

## Requirements
- R1: After synchronous reset, `irq_o`, `nmi_o` and `srst_o` are low, `stage_o` reads 0, and the watchdog is disabled.
- R2: A configuration write starts a period of exactly `len × 2^(LOW_BITS+PRE_LOG2)` clock cycles. The first expiry becomes visible on the outputs right after the clock edge that ends this period, and no earlier.
- R3: The first expiry without a poke sets `stage_o` to 1 and raises `irq_o`, and a new period of the same length begins. Stage codes are 0 = counting, 1 = interrupt, 2 = NMI, 3 = reset issued.
- R4: A second unrefreshed expiry sets `stage_o` to 2 (bit 1 set) and raises `nmi_o`, while `irq_o` stays high.
- R5: A third unrefreshed expiry in mode 3 raises `srst_o` for exactly one cycle, with `stage_o` = 3 in that cycle. The block then returns to stage 0 and is disabled, so no output rises again until the next configuration write.
- R6: The mode field is 2 bits wide: 0 = off, 1 = interrupt only, 2 = interrupt then NMI, 3 = interrupt, NMI, then reset. Further expiries leave the block at the last stage its mode enables.
- R7: With mode 0, or with length 0, the watchdog is disabled. The stage stays 0 and no output rises.
- R8: A poke while enabled clears the stage to 0 in the next cycle and restarts a full period, including the prescaler phase.
- R9: A configuration write clears the stage to 0 and starts a full period with the new length.
- R10: When a poke lands in the same cycle as an expiry, the poke wins. The stage stays 0 and a full new period starts.
- R11: A poke while disabled has no effect. The stage stays 0 and no output rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for length and mode |
| cfg_len | input | 16 | Reload length, upper bits of the down-counter |
| cfg_mode | input | 2 | Escalation mode (0 off, 1, 2, 3) |
| poke | input | 1 | Refresh: clears stage and restarts the period |
| irq_o | output | 1 | Interrupt, high in stages 1 and 2 |
| nmi_o | output | 1 | Non-maskable interrupt, high in stage 2 |
| srst_o | output | 1 | One-cycle soft-reset request |
| stage_o | output | 2 | Current stage readback |

## Verification
Three events can fall on the same clock edge: a poke, a configuration write, and a period expiry. The directed part of the bench steps a one-unit period up to the very cycle of expiry and pokes there. It then checks that the stage remains 0 and that the interrupt appears only one full period later. The random part issues rare pokes and writes at random cycles, so some of them land on expiry edges, on the one-cycle reset stage, and on writes. A per-cycle reference model, with poke and write given priority over expiry, decides the expected stage and outputs for every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int LEN_W = 16;

    typedef enum logic [1:0] {
        ST_COUNT = 2'd0,
        ST_IRQ   = 2'd1,
        ST_NMI   = 2'd2,
        ST_RST   = 2'd3
    } stage_e;

    typedef enum logic [1:0] {
        MD_OFF  = 2'd0,
        MD_IRQ  = 2'd1,
        MD_NMI  = 2'd2,
        MD_FULL = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e             mode;
        logic [LEN_W-1:0]  len;
    } cfg_t;

    function automatic logic cfg_active(input cfg_t c);
        return (c.mode != MD_OFF) && (c.len != '0);
    endfunction

    function automatic stage_e escalate(input stage_e s, input mode_e m);
        stage_e r;
        r = s;
        case (s)
            ST_COUNT: if (m != MD_OFF)  r = ST_IRQ;
            ST_IRQ:   if (m == MD_NMI || m == MD_FULL) r = ST_NMI;
            ST_NMI:   if (m == MD_FULL) r = ST_RST;
            default:  r = ST_COUNT;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRE_LOG2 = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam int PW = (PRE_LOG2 < 1) ? 1 : PRE_LOG2;

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            pre_q <= '0;
        else if (run_i)
            pre_q <= pre_q + 1'b1;
    end

    assign tick_o = run_i && !clear_i && (&pre_q);

    // R2: ticks are spaced; two in a row would shorten the period
    a_r2_tick_spaced: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
    parameter int LEN_W    = 16,
    parameter int LOW_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             tick_i,
    output logic             expire_o
);
    localparam int CNT_W = LEN_W + LOW_BITS;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    assign reload   = {len_i, {LOW_BITS{1'b0}}};
    assign expire_o = tick_i && !load_i && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i || expire_o)
            cnt_q <= reload;
        else if (tick_i)
            cnt_q <= cnt_q - 1'b1;
    end

    // R2: the count only moves on a prescaler tick or a reload
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_stage_fsm.sv
module wdog_stage_fsm
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cfg_we_i,
    input  logic   en_i,
    input  logic   poke_i,
    input  logic   expire_i,
    input  mode_e  mode_i,
    output stage_e stage_o,
    output logic   fire_rst_o
);
    stage_e stage_q, stage_d;

    always_comb begin
        stage_d = stage_q;
        if (cfg_we_i || !en_i)
            stage_d = ST_COUNT;
        else if (stage_q == ST_RST)
            stage_d = ST_COUNT;
        else if (poke_i)
            stage_d = ST_COUNT;
        else if (expire_i)
            stage_d = escalate(stage_q, mode_i);
    end

    assign fire_rst_o = en_i && !cfg_we_i && !poke_i && expire_i &&
                        (stage_q == ST_NMI) && (mode_i == MD_FULL);

    always_ff @(posedge clk) begin
        if (rst) stage_q <= ST_COUNT;
        else     stage_q <= stage_d;
    end

    assign stage_o = stage_q;

    // R8: poke while enabled returns to counting
    a_r8_poke_clears: assert property (@(posedge clk) disable iff (rst)
        (poke_i && en_i) |=> (stage_q == ST_COUNT));
    // R7: a disabled watchdog sits in stage 0
    a_r7_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (stage_q == ST_COUNT));
    // R3: from counting, only one stage may be climbed per expiry
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_COUNT) |=> (stage_q != ST_NMI && stage_q != ST_RST));
    // R5: the reset stage lasts one cycle
    a_r5_rst_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (stage_q == ST_RST) |=> (stage_q == ST_COUNT));

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
    import wdog_pkg::*;
#(
    parameter int PRE_LOG2 = 8,
    parameter int LOW_BITS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [1:0]       cfg_mode,
    input  logic             poke,
    output logic             irq_o,
    output logic             nmi_o,
    output logic             srst_o,
    output logic [1:0]       stage_o
);
    cfg_t             cfg_q;
    logic             en;
    logic             restart;
    logic             tick;
    logic             expire;
    logic             fire_rst;
    logic [LEN_W-1:0] load_len;
    stage_e           stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mode <= MD_OFF;
            cfg_q.len  <= '0;
        end else if (cfg_we) begin
            cfg_q.mode <= mode_e'(cfg_mode);
            cfg_q.len  <= cfg_len;
        end else if (fire_rst) begin
            cfg_q.mode <= MD_OFF;
        end
    end

    assign en       = cfg_active(cfg_q);
    assign restart  = cfg_we || poke;
    assign load_len = cfg_we ? cfg_len : cfg_q.len;

    wdog_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run_i   (en),
        .clear_i (restart),
        .tick_o  (tick)
    );

    wdog_downcount #(.LEN_W(LEN_W), .LOW_BITS(LOW_BITS)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_i   (restart),
        .len_i    (load_len),
        .tick_i   (tick),
        .expire_o (expire)
    );

    wdog_stage_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg_we_i   (cfg_we),
        .en_i       (en),
        .poke_i     (poke),
        .expire_i   (expire),
        .mode_i     (cfg_q.mode),
        .stage_o    (stage),
        .fire_rst_o (fire_rst)
    );

    assign irq_o   = (stage == ST_IRQ) || (stage == ST_NMI);
    assign nmi_o   = (stage == ST_NMI);
    assign srst_o  = (stage == ST_RST);
    assign stage_o = stage;

    // R5: the reset request is a single pulse followed by silence
    a_r5_srst_pulse: assert property (@(posedge clk) disable iff (rst)
        srst_o |=> (!srst_o && !irq_o));
    // R10: a poke while enabled with no write always drops the interrupt
    a_r10_poke_wins: assert property (@(posedge clk) disable iff (rst)
        (poke && en && !cfg_we) |=> !irq_o);
    // R11: a poke while disabled leaves the outputs low
    a_r11_poke_off: assert property (@(posedge clk) disable iff (rst)
        (poke && !en && !cfg_we) |=> (!irq_o && !nmi_o));

endmodule

// File: tb/wdog_escalator_test.sv
`timescale 1ns/1ps
module wdog_escalator_test;

    localparam int PRE = 2;
    localparam int LOW = 2;
    localparam int UNIT = 1 << (PRE + LOW);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [15:0] len = '0;
    logic [1:0]  mode = '0;
    logic        poke = 1'b0;
    logic        irq_o, nmi_o, srst_o;
    logic [1:0]  stage_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wdog_escalator #(.PRE_LOG2(PRE), .LOW_BITS(LOW)) uut (
        .clk(clk), .rst(rst), .cfg_we(we), .cfg_len(len), .cfg_mode(mode),
        .poke(poke), .irq_o(irq_o), .nmi_o(nmi_o), .srst_o(srst_o),
        .stage_o(stage_o)
    );

    // reference model built from the requirements
    logic [1:0]  m_mode, m_stage;
    logic [15:0] m_len;
    int          m_el;

    function automatic logic [1:0] next_stage(input logic [1:0] s, input logic [1:0] m);
        if (s == 2'd0 && m >= 2'd1) return 2'd1;
        if (s == 2'd1 && m >= 2'd2) return 2'd2;
        if (s == 2'd2 && m == 2'd3) return 2'd3;
        return s;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode <= 0; m_len <= 0; m_stage <= 0; m_el <= 0;
        end else if (we) begin
            m_mode <= mode; m_len <= len; m_stage <= 0; m_el <= 0;
        end else if (m_stage == 2'd3) begin
            m_stage <= 0;
        end else if (m_mode != 0 && m_len != 0) begin
            if (poke) begin
                m_stage <= 0; m_el <= 0;
            end else if (m_el + 1 == int'(m_len) * UNIT) begin
                m_el <= 0;
                m_stage <= next_stage(m_stage, m_mode);
                if (m_stage == 2'd2 && m_mode == 2'd3) m_mode <= 0;
            end else begin
                m_el <= m_el + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (mon_on && !rst) begin
            chk("R3 stage", stage_o, m_stage);
            chk("R3 irq", irq_o, (m_stage == 1 || m_stage == 2));
            chk("R4 nmi", nmi_o, (m_stage == 2));
            chk("R5 srst", srst_o, (m_stage == 3));
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input int l, input int m);
        we = 1'b1; len = 16'(l); mode = 2'(m);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_poke();
        poke = 1'b1;
        @(negedge clk);
        poke = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        run(4);
        rst = 1'b0;
        run(1);
        chk("R1 stage", stage_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 nmi", nmi_o, 0);
        chk("R1 srst", srst_o, 0);
        mon_on = 1'b1;

        // R7 disabled by length 0 or mode 0
        write_cfg(0, 3); run(200);
        chk("R7 len0 stage", stage_o, 0);
        write_cfg(3, 0); run(200);
        chk("R7 mode0 irq", irq_o, 0);
        // R11 poke while disabled
        do_poke(); run(2);
        chk("R11 stage", stage_o, 0);

        // R2/R3/R4/R5 full escalation, period 2*UNIT
        write_cfg(2, 3);
        run(2*UNIT - 1); chk("R2 early irq", irq_o, 0);
        run(1);          chk("R2 irq on time", irq_o, 1);
        chk("R3 stage1", stage_o, 1);
        run(2*UNIT - 1); chk("R4 early nmi", nmi_o, 0);
        run(1);          chk("R4 nmi", nmi_o, 1);
        chk("R4 stage2", stage_o, 2); chk("R4 irq held", irq_o, 1);
        run(2*UNIT - 1); chk("R5 early srst", srst_o, 0);
        run(1);          chk("R5 srst", srst_o, 1);
        chk("R5 stage3", stage_o, 3);
        run(1);          chk("R5 pulse ends", srst_o, 0);
        chk("R5 stage back", stage_o, 0);
        run(10*UNIT);    chk("R5 disabled after", irq_o, 0);

        // R6 mode clamps
        write_cfg(1, 1);
        run(UNIT); chk("R6 m1 stage1", stage_o, 1);
        run(4*UNIT); chk("R6 m1 holds", stage_o, 1); chk("R6 m1 no nmi", nmi_o, 0);
        write_cfg(1, 2);
        run(2*UNIT); chk("R6 m2 stage2", stage_o, 2);
        run(4*UNIT); chk("R6 m2 holds", stage_o, 2); chk("R6 m2 no srst", srst_o, 0);

        // R8 poke clears and restarts a full period
        write_cfg(2, 3);
        run(2*UNIT); chk("R8 pre stage", stage_o, 1);
        do_poke();   chk("R8 cleared", stage_o, 0); chk("R8 irq low", irq_o, 0);
        run(2*UNIT - 1); chk("R8 full period", irq_o, 0);
        run(1);      chk("R8 expiry again", irq_o, 1);

        // R9 config write restarts with the new length
        write_cfg(1, 3); chk("R9 cleared", stage_o, 0);
        run(UNIT - 1); chk("R9 early", stage_o, 0);
        run(1);        chk("R9 new len", stage_o, 1);

        // R10 poke on the expiry edge
        write_cfg(1, 3);
        run(UNIT - 1);
        do_poke();   chk("R10 poke wins", stage_o, 0);
        run(UNIT - 1); chk("R10 still 0", stage_o, 0);
        run(1);        chk("R10 next expiry", stage_o, 1);

        // random phase, reference model checks every cycle
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 150 == 0) begin
                we = 1'b1; len = 16'($urandom % 4); mode = 2'($urandom % 4);
            end
            if ($urandom % 120 == 0) poke = 1'b1;
            @(negedge clk);
            we = 1'b0; poke = 1'b0;
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule